// File: doc/BRIEF.md
# Dual PS/2 Port Register Front End

This block sits between a processor bus and two external PS/2 byte serializers, one for a keyboard and one for a mouse. Each port has its own register window, chosen by the address bit just above the window. Inside a window, address bits [3:2] pick a register. The block returns a byte for each read and acts on each write. It also merges the two per-port interrupts into one interrupt line.

On the device side, each port gives out bytes through a valid/ready pair and pops received bytes from a queue. That queue reports whether it is non-empty and shows its head byte. A control register can put a port into loopback mode. In loopback, a transmitted byte is kept locally and comes back as received data. A diagnostic mode lets the direction bits clear the line-state status bits.

Each port's transmit side is a two-state machine. In TX_IDLE, a transmit write outside loopback moves it to TX_OFFER, where the byte is held on the device interface. In TX_OFFER, tx_ready moves it back to TX_IDLE. A new transmit write while in TX_OFFER keeps it in TX_OFFER with the new byte.

Top module: `ps2_dual_regif`

## Requirements
- R1: A request is accepted in the cycle req_valid is high. The port index is req_addr[8], and the register is req_addr[3:2]. Reads select 0 = identity, 1 = receive data, 2 = control, 3 = status. Writes select 0 = reset (no action), 1 = transmit data, 2 = control, 3 = ignored. Read data appears on rd_data with rd_valid high in the next cycle only.
- R2: The identity register reads 0x00 on port 0 (keyboard) and 0x01 on port 1 (mouse).
- R3: Control is an 8-bit register. It reads back the last byte written to it and changes on no other access. Its bits are: bit0 enable, bit1 loopback, bit5 diagnostic, bit6 data direction, bit7 clock direction.
- R4: Outside loopback, a transmit write shows the byte on tx_data with tx_valid high from the next cycle. It stays there until a cycle with tx_ready high. A second write before acceptance replaces the byte.
- R5: In loopback, a transmit write never raises tx_valid. It stores the byte locally, sets that port's interrupt and sets the loopback not-empty flag.
- R6: In loopback, a receive-data read returns the stored byte and clears both the port interrupt and the loopback not-empty flag.
- R7: Outside loopback, a receive-data read returns rx_data of that port. In the same cycle it pulses rx_pop for that port, if rx_nonempty is high.
- R8: Status bit7 (clock line) and bit6 (data line) read 1. When control bit5 is set, each reads 0 while its direction bit (bit7 or bit6) is clear.
- R9: Status bit0 shows the loopback not-empty flag while loopback is set, and rx_nonempty of the port otherwise.
- R10: Outside loopback, a port interrupt follows dev_irq with one cycle of delay. The irq output and status bit4 of both ports are the OR of the two port interrupts.
- R11: Status bits 1, 2, 3 and 5 read 0. A write to the reset register leaves every register unchanged.
- R12: While rst_n is low at a clock edge, control, the loopback flags, the interrupts and the transmit state return to zero or idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Bus request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 9 | Byte address: bit8 selects the port, bits[3:2] select the register |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 8 | Read data |
| irq | output | 1 | Combined interrupt |
| tx_valid | output | 2 | Per-port byte offered to the serializer |
| tx_data | output | 2x8 | Per-port byte to send |
| tx_ready | input | 2 | Per-port serializer accepts the byte |
| rx_pop | output | 2 | Per-port pop of the receive queue head |
| rx_data | input | 2x8 | Per-port receive queue head |
| rx_nonempty | input | 2 | Per-port receive queue holds data |
| dev_irq | input | 2 | Per-port level interrupt from the serializer |

## Verification
The assertions assume at most one bus request per cycle. The held-byte property assumes tx_ready is only meaningful while tx_valid is high. The one-hot pop check assumes a read never targets both ports at once. The stimulus uses tasks that raise req_valid for exactly one cycle, followed by an idle cycle. rx_data and rx_nonempty change only between accesses, and tx_ready is pulsed for a single cycle while a byte is offered.

// File: rtl/ps2_regif_pkg.sv
package ps2_regif_pkg;

    localparam int DATA_W = 8;

    // register selectors, taken from address bits [3:2]
    localparam logic [1:0] SEL_ID   = 2'd0;
    localparam logic [1:0] SEL_RX   = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;
    localparam logic [1:0] SEL_RST  = 2'd0;
    localparam logic [1:0] SEL_TX   = 2'd1;

    // control bit positions
    localparam int CB_LOOP = 1;
    localparam int CB_DIAG = 5;
    localparam int CB_DDIR = 6;
    localparam int CB_CDIR = 7;

    // status bit positions
    localparam int SB_RBNE = 0;
    localparam int SB_CMP  = 4;
    localparam int SB_DAT  = 6;
    localparam int SB_CLK  = 7;

    typedef enum logic {
        TX_IDLE  = 1'b0,
        TX_OFFER = 1'b1
    } tx_state_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [1:0]        sel;
        logic [DATA_W-1:0] wdata;
    } port_req_t;

endpackage

// File: rtl/ps2_bus_decode.sv
module ps2_bus_decode
    import ps2_regif_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int WIN_BITS  = 8,
    localparam int SEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int ADDR_W   = WIN_BITS + SEL_W
) (
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [DATA_W-1:0]          req_wdata,
    output port_req_t [NUM_PORTS-1:0]  preq,
    output logic [SEL_W-1:0]           sel_port,
    output logic                       rd_any
);

    logic unused_addr_bits;
    assign unused_addr_bits = ^{req_addr[1:0], req_addr[WIN_BITS-1:4]};

    assign sel_port = req_addr[ADDR_W-1 -: SEL_W];
    assign rd_any   = req_valid && !req_write;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port_req
        logic hit;
        assign hit           = req_valid && (sel_port == SEL_W'(g));
        assign preq[g].rd    = hit && !req_write;
        assign preq[g].wr    = hit && req_write;
        assign preq[g].sel   = req_addr[3:2];
        assign preq[g].wdata = req_wdata;
    end

endmodule

// File: rtl/ps2_port_regs.sv
module ps2_port_regs
    import ps2_regif_pkg::*;
#(
    parameter int PORT_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_req_t         req,
    input  logic              any_irq,
    output logic [DATA_W-1:0] rd_byte,
    output logic              port_irq,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready,
    output logic              rx_pop,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_nonempty,
    input  logic              dev_irq
);

    tx_state_e         tx_state, tx_next;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] tx_byte_q;
    logic [DATA_W-1:0] lb_buf_q;
    logic              lb_full_q;
    logic              irq_q;

    logic loop_on, wr_tx, wr_ctl, rd_rx, lb_wr, lb_rd, dev_wr;

    assign loop_on = ctrl_q[CB_LOOP];
    assign wr_tx   = req.wr && (req.sel == SEL_TX);
    assign wr_ctl  = req.wr && (req.sel == SEL_CTRL);
    assign rd_rx   = req.rd && (req.sel == SEL_RX);
    assign lb_wr   = wr_tx && loop_on;
    assign dev_wr  = wr_tx && !loop_on;
    assign lb_rd   = rd_rx && loop_on;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) tx_state <= TX_IDLE;
        else        tx_state <= tx_next;
    end

    // next state
    always_comb begin
        tx_next = tx_state;
        unique case (tx_state)
            TX_IDLE:  if (dev_wr) tx_next = TX_OFFER;
            TX_OFFER: if (dev_wr)        tx_next = TX_OFFER;
                      else if (tx_ready) tx_next = TX_IDLE;
        endcase
    end

    // outputs of the transmit machine
    always_comb begin
        tx_valid = (tx_state == TX_OFFER);
        tx_data  = tx_byte_q;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            tx_byte_q <= '0;
            lb_buf_q  <= '0;
            lb_full_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            if (wr_ctl) ctrl_q <= req.wdata;
            if (dev_wr) tx_byte_q <= req.wdata;
            if (lb_wr) begin
                lb_buf_q  <= req.wdata;
                lb_full_q <= 1'b1;
                irq_q     <= 1'b1;
            end else if (lb_rd) begin
                lb_full_q <= 1'b0;
                irq_q     <= 1'b0;
            end else if (!loop_on) begin
                irq_q     <= dev_irq;
            end
        end
    end

    assign port_irq = irq_q;
    assign rx_pop   = rd_rx && !loop_on && rx_nonempty;

    // read mux
    logic [DATA_W-1:0] stat;
    always_comb begin
        stat          = '0;
        stat[SB_CLK]  = !(ctrl_q[CB_DIAG] && !ctrl_q[CB_CDIR]);
        stat[SB_DAT]  = !(ctrl_q[CB_DIAG] && !ctrl_q[CB_DDIR]);
        stat[SB_CMP]  = any_irq;
        stat[SB_RBNE] = loop_on ? lb_full_q : rx_nonempty;
    end

    always_comb begin
        unique case (req.sel)
            SEL_ID:   rd_byte = DATA_W'(PORT_ID);
            SEL_RX:   rd_byte = loop_on ? lb_buf_q : rx_data;
            SEL_CTRL: rd_byte = ctrl_q;
            SEL_STAT: rd_byte = stat;
        endcase
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready && !wr_tx |=> tx_valid && $stable(tx_data)); // R4
    AST_LB_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
        lb_wr && !tx_valid |=> !tx_valid); // R5
    AST_LB_SET: assert property (@(posedge clk) disable iff (!rst_n)
        lb_wr |=> port_irq && lb_full_q); // R5
    AST_LB_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        lb_rd |=> !port_irq && !lb_full_q); // R6
    AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctl |=> $stable(ctrl_q)); // R3

endmodule

// File: rtl/ps2_rd_return.sv
module ps2_rd_return
    import ps2_regif_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    localparam int SEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               rd_any,
    input  logic [SEL_W-1:0]                   sel_port,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]   port_bytes,
    output logic                               rd_valid,
    output logic [DATA_W-1:0]                  rd_data
);

    logic [DATA_W-1:0] pick;
    always_comb begin
        pick = '0;
        for (int i = 0; i < NUM_PORTS; i++)
            if (sel_port == SEL_W'(i)) pick = port_bytes[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_any;
            if (rd_any) rd_data <= pick;
        end
    end

endmodule

// File: rtl/ps2_dual_regif.sv
module ps2_dual_regif
    import ps2_regif_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int WIN_BITS  = 8,
    localparam int SEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int ADDR_W   = WIN_BITS + SEL_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             req_valid,
    input  logic                             req_write,
    input  logic [ADDR_W-1:0]                req_addr,
    input  logic [DATA_W-1:0]                req_wdata,
    output logic                             rd_valid,
    output logic [DATA_W-1:0]                rd_data,
    output logic                             irq,
    output logic [NUM_PORTS-1:0]             tx_valid,
    output logic [NUM_PORTS-1:0][DATA_W-1:0] tx_data,
    input  logic [NUM_PORTS-1:0]             tx_ready,
    output logic [NUM_PORTS-1:0]             rx_pop,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0] rx_data,
    input  logic [NUM_PORTS-1:0]             rx_nonempty,
    input  logic [NUM_PORTS-1:0]             dev_irq
);

    port_req_t [NUM_PORTS-1:0]         preq;
    logic [SEL_W-1:0]                  sel_port;
    logic                              rd_any;
    logic [NUM_PORTS-1:0][DATA_W-1:0]  port_bytes;
    logic [NUM_PORTS-1:0]              port_irq;

    ps2_bus_decode #(.NUM_PORTS(NUM_PORTS), .WIN_BITS(WIN_BITS)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .preq      (preq),
        .sel_port  (sel_port),
        .rd_any    (rd_any)
    );

    assign irq = |port_irq;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        ps2_port_regs #(.PORT_ID(p)) u_port (
            .clk         (clk),
            .rst_n       (rst_n),
            .req         (preq[p]),
            .any_irq     (irq),
            .rd_byte     (port_bytes[p]),
            .port_irq    (port_irq[p]),
            .tx_valid    (tx_valid[p]),
            .tx_data     (tx_data[p]),
            .tx_ready    (tx_ready[p]),
            .rx_pop      (rx_pop[p]),
            .rx_data     (rx_data[p]),
            .rx_nonempty (rx_nonempty[p]),
            .dev_irq     (dev_irq[p])
        );
    end

    ps2_rd_return #(.NUM_PORTS(NUM_PORTS)) u_ret (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_any     (rd_any),
        .sel_port   (sel_port),
        .port_bytes (port_bytes),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    AST_RD_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write |=> rd_valid); // R1
    AST_NO_STRAY_RD: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid); // R1
    AST_POP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_pop)); // R7
    AST_CMP_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && $past(req_valid && !req_write && req_addr[3:2] == SEL_STAT)
        |-> rd_data[SB_CMP] == $past(irq)); // R10

endmodule

// File: tb/tb_ps2_dual_regif.sv
module tb_ps2_dual_regif;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [8:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic rd_valid, irq;
    logic [7:0] rd_data;
    logic [1:0] tx_valid, rx_pop;
    logic [1:0][7:0] tx_data;
    logic [1:0] tx_ready = '0, rx_nonempty = '0, dev_irq = '0;
    logic [1:0][7:0] rx_data;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit started = 0;

    always #5 clk = ~clk;

    ps2_dual_regif dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .irq(irq), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_pop(rx_pop), .rx_data(rx_data),
        .rx_nonempty(rx_nonempty), .dev_irq(dev_irq)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // ---------------- reference model ----------------
    int  m_ctrl[2], m_buf[2], m_byte[2];
    bit  m_lbf[2], m_irq[2], m_pend[2];
    bit  m_rv;
    int  m_rd;
    string m_tag;

    function automatic int model_status(int p);
        int s;
        s = 8'hC0;
        if (m_ctrl[p] & 8'h20) begin
            if (!(m_ctrl[p] & 8'h40)) s &= ~8'h40;
            if (!(m_ctrl[p] & 8'h80)) s &= ~8'h80;
        end
        if (m_ctrl[p] & 2) begin if (m_lbf[p]) s |= 1; end
        else if (rx_nonempty[p]) s |= 1;
        if (m_irq[0] || m_irq[1]) s |= 8'h10;
        return s;
    endfunction

    always @(posedge clk) begin
        int p, r;
        cyc++;
        if (!rst_n) begin
            started = 1;
            for (int i = 0; i < 2; i++) begin
                m_ctrl[i] = 0; m_buf[i] = 0; m_byte[i] = 0;
                m_lbf[i] = 0; m_irq[i] = 0; m_pend[i] = 0;
            end
            m_rv = 0;
        end else begin
            m_rv = 0;
            p = int'(req_addr[8]);
            r = int'(req_addr[3:2]);
            if (req_valid && !req_write) begin
                m_rv = 1;
                case (r)
                    0: begin m_rd = p; m_tag = "R2"; end
                    1: if (m_ctrl[p] & 2) begin m_rd = m_buf[p]; m_tag = "R6"; end
                       else begin m_rd = rx_data[p]; m_tag = "R7"; end
                    2: begin m_rd = m_ctrl[p]; m_tag = "R3"; end
                    default: begin m_rd = model_status(p); m_tag = "R9"; end
                endcase
            end
            for (int i = 0; i < 2; i++) begin
                if (m_pend[i] && tx_ready[i]) m_pend[i] = 0;
                if (!(m_ctrl[i] & 2)) m_irq[i] = dev_irq[i];
            end
            if (req_valid && !req_write && r == 1 && (m_ctrl[p] & 2)) begin
                m_irq[p] = 0; m_lbf[p] = 0;
            end
            if (req_valid && req_write) begin
                if (r == 1) begin
                    if (m_ctrl[p] & 2) begin
                        m_buf[p] = req_wdata; m_irq[p] = 1; m_lbf[p] = 1;
                    end else begin
                        m_pend[p] = 1; m_byte[p] = req_wdata;
                    end
                end else if (r == 2) m_ctrl[p] = req_wdata;
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            check(rd_valid == m_rv, "R1 rd_valid", rd_valid, m_rv);
            if (m_rv) check(rd_data == m_rd[7:0], m_tag, rd_data, m_rd);
            check(irq == (m_irq[0] | m_irq[1]), "R10 irq", irq, m_irq[0] | m_irq[1]);
            for (int i = 0; i < 2; i++) begin
                bit ep;
                check(tx_valid[i] == m_pend[i], "R4/R5 tx_valid", tx_valid[i], m_pend[i]);
                if (m_pend[i]) check(tx_data[i] == m_byte[i][7:0], "R4 tx_data", tx_data[i], m_byte[i]);
                ep = rst_n && req_valid && !req_write && req_addr[3:2] == 2'd1 &&
                     int'(req_addr[8]) == i && !(m_ctrl[i] & 2) && rx_nonempty[i];
                check(rx_pop[i] == ep, "R7 rx_pop", rx_pop[i], ep);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic bus_wr(int p, int off, int val);
        @(posedge clk); #1;
        req_valid = 1; req_write = 1; req_addr = 9'((p << 8) | off); req_wdata = 8'(val);
        @(posedge clk); #1;
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd_expect(int p, int off, int exp, string tag);
        @(posedge clk); #1;
        req_valid = 1; req_write = 0; req_addr = 9'((p << 8) | off);
        @(posedge clk); #1;
        req_valid = 0;
        check(rd_valid && rd_data == exp[7:0], tag, rd_data, exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        rx_data[0] = 8'h5A; rx_data[1] = 8'hA5;
        idle(3);
        rst_n = 1;
        rd_expect(0, 8, 8'h00, "R12 ctrl after reset");
        rd_expect(0, 0, 8'h00, "R2 keyboard id");
        rd_expect(1, 0, 8'h01, "R2 mouse id");
        rd_expect(0, 12, 8'hC0, "R8 default status");
        bus_wr(1, 8, 8'h81);
        rd_expect(1, 8, 8'h81, "R3 ctrl readback");
        // device transmit with a replacement before acceptance
        bus_wr(0, 4, 8'h11);
        idle(2);
        bus_wr(0, 4, 8'h22);
        idle(1);
        check(tx_valid[0] && tx_data[0] == 8'h22, "R4 replaced byte", tx_data[0], 8'h22);
        tx_ready[0] = 1; idle(1); tx_ready[0] = 0;
        check(!tx_valid[0], "R4 accepted", tx_valid[0], 0);
        // device receive
        rx_nonempty[0] = 1;
        rd_expect(0, 4, 8'h5A, "R7 receive from device");
        rd_expect(0, 12, 8'hC1, "R9 rbne from device");
        // device interrupt
        dev_irq[1] = 1; idle(2);
        check(irq == 1, "R10 irq follows device", irq, 1);
        rd_expect(0, 12, 8'hD1, "R10 combined bit in other port");
        dev_irq[1] = 0; idle(2);
        check(irq == 0, "R10 irq drops", irq, 0);
        // loopback on port 1
        bus_wr(1, 8, 8'h02);
        bus_wr(1, 4, 8'h3C);
        check(!tx_valid[1] && irq, "R5 loopback write", {tx_valid[1], irq}, 2'b01);
        rd_expect(1, 12, 8'hD1, "R5 loopback status");
        rd_expect(1, 4, 8'h3C, "R6 loopback read");
        rd_expect(1, 12, 8'hC0, "R6 loopback cleared");
        // diagnostic direction masks
        bus_wr(0, 8, 8'h20); rd_expect(0, 12, 8'h01, "R8 diag both clear");
        bus_wr(0, 8, 8'h60); rd_expect(0, 12, 8'h41, "R8 diag data dir");
        bus_wr(0, 8, 8'hA0); rd_expect(0, 12, 8'h81, "R8 diag clock dir");
        bus_wr(0, 8, 8'hE0); rd_expect(0, 12, 8'hC1, "R8 diag both set");
        // reset register and unused write slot
        bus_wr(0, 0, 8'hFF);
        rd_expect(0, 8, 8'hE0, "R11 reset register write ignored");
        bus_wr(0, 12, 8'h00);
        rd_expect(0, 8, 8'hE0, "R1 write slot 3 ignored");
        // synchronous reset in the middle of a loopback transfer
        bus_wr(0, 8, 8'h02);
        bus_wr(0, 4, 8'h77);
        bus_wr(1, 8, 8'h00);
        bus_wr(1, 4, 8'h99);
        rst_n = 0; idle(2); rst_n = 1;
        check(!irq && tx_valid == 2'b00, "R12 flags after reset", {irq, tx_valid}, 0);
        rd_expect(0, 8, 8'h00, "R12 ctrl cleared");
        rd_expect(0, 12, 8'hC1, "R12 loopback flag cleared");
        idle(3);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

endmodule